// File: doc/BRIEF.md
# Stream Handshake Monitor

A passive, synthesizable checker that sits beside one valid/ready stream channel carrying a parameterized payload. It never drives the channel. Each clock it compares the present values of `mon_valid`, `mon_ready` and `mon_data` with the values it captured one cycle earlier. From that comparison it reports three handshake faults: the sender withdrawing valid before a beat was accepted, the receiver withdrawing ready before it saw a beat offered, and the payload moving while a beat is stalled. It also counts back-to-back stall cycles and raises a bounded-liveness timeout when the count reaches a limit.

Two small state machines carry the control. The history machine has two states. HIST_COLD is entered on reset, and in it every previous-cycle rule is suppressed. The transition COLD→WARM is taken on the first clock edge sampled out of reset, and HIST_WARM holds until the next reset. The stall machine has three states: STL_IDLE (no stall), STL_STALLING (counting) and STL_EXPIRED (limit reached, count held). Its transitions are IDLE→STALLING on a stall cycle, STALLING→STALLING while the stall continues below the limit, STALLING→EXPIRED when the count reaches the limit, EXPIRED→EXPIRED while stalled, and any state→IDLE on a non-stall cycle.

Every fault is latched in its own sticky flag. A build parameter states whether the sender or the receiver is the unit under test. The flags are then split into a design-error output for that side and an environment-error output for the other side.

Top module: `stream_proto_monitor`

## Requirements
- R1: While reset (`rst_n` low) is asserted and in the first cycle after it, every error output is 0 and `stall_count` is 0.
- R2: A cycle with `mon_valid` low, whose previous cycle had `mon_valid` high and `mon_ready` low, sets `err_valid_drop` after that clock edge.
- R3: A cycle with `mon_ready` low, whose previous cycle had `mon_ready` high and `mon_valid` low, sets `err_ready_drop` after that clock edge.
- R4: A cycle whose previous cycle had `mon_valid` high and `mon_ready` low, and whose `mon_data` differs from the previous cycle's, sets `err_data_change` after that clock edge.
- R5: Legal traffic raises no flag. Legal traffic includes back-to-back transfers with changing payload, valid or ready falling right after a transfer, ready rising with no valid, and a stable stalled payload.
- R6: In the first sampled cycle after reset no previous-cycle rule (R2, R3, R4) fires, whatever the channel carried during reset.
- R7: Every error flag stays set until reset. `err_any` is the OR of the four flags.
- R8: `stall_count` increments after each edge that samples `mon_valid` high and `mon_ready` low, and it is 0 after any other edge.
- R9: `stall_count` saturates at `STALL_LIMIT` (default 1000). `err_timeout` is set at the edge where the count reaches the limit and not before.
- R10: With `MASTER_IS_DUT`=1, `dut_err` is the OR of `err_valid_drop` and `err_data_change`, and `env_err` is the OR of `err_ready_drop` and `err_timeout`. With `MASTER_IS_DUT`=0 the two roles are swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_valid | input | 1 | Observed sender valid |
| mon_ready | input | 1 | Observed receiver ready |
| mon_data | input | DATA_W | Observed payload |
| err_valid_drop | output | 1 | Sticky: valid withdrawn without a transfer |
| err_ready_drop | output | 1 | Sticky: ready withdrawn without valid |
| err_data_change | output | 1 | Sticky: payload changed while stalled |
| err_timeout | output | 1 | Sticky: stall reached STALL_LIMIT |
| err_any | output | 1 | OR of the four flags |
| dut_err | output | 1 | Flags owned by the side under test |
| env_err | output | 1 | Flags owned by the other side |
| stall_count | output | $clog2(STALL_LIMIT+1) | Consecutive stall cycles, saturating |

## Verification
A vector sequence covers several cases. Fully legal streams check that the monitor stays quiet on bursts, on back-to-back transfers and on ready idling high. Three single-fault cases each trip exactly one flag, which shows the three rules apart. Reset rows are placed directly after a stalled, high-valid cycle, so only the cold-state gating keeps the monitor silent in that case. A second instance with the opposite side selection shows that the design/environment split follows the parameter. A directed run of 999, 1000 and 1005 stall cycles then shows where the timeout sets and that the counter holds at the limit rather than wrapping.

// File: rtl/mon_pkg.sv
package mon_pkg;

    typedef enum logic {
        HIST_COLD,
        HIST_WARM
    } hist_state_e;

    typedef enum logic [1:0] {
        STL_IDLE,
        STL_STALLING,
        STL_EXPIRED
    } stall_state_e;

    localparam int NUM_FLAGS        = 4;
    localparam int FLAG_VALID_DROP  = 0;
    localparam int FLAG_READY_DROP  = 1;
    localparam int FLAG_DATA_CHANGE = 2;
    localparam int FLAG_TIMEOUT     = 3;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;

    // Flags owned by the sender side when master_side is set, else by the receiver.
    function automatic flag_vec_t side_mask(input logic master_side);
        flag_vec_t sender_bits;
        sender_bits = '0;
        sender_bits[FLAG_VALID_DROP]  = 1'b1;
        sender_bits[FLAG_DATA_CHANGE] = 1'b1;
        return master_side ? sender_bits : ~sender_bits;
    endfunction

endpackage

// File: rtl/mon_history.sv
module mon_history
    import mon_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cur_valid,
    input  logic              cur_ready,
    input  logic [DATA_W-1:0] cur_data,
    output logic              hist_warm,
    output logic              prev_valid,
    output logic              prev_ready,
    output logic [DATA_W-1:0] prev_data
);

    hist_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HIST_COLD;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HIST_COLD: state_d = HIST_WARM;
            HIST_WARM: state_d = HIST_WARM;
            default:   state_d = HIST_COLD;
        endcase
    end

    // Outputs
    always_comb begin
        hist_warm = (state_q == HIST_WARM);
    end

    // Previous-cycle capture; deliberately not reset, the cold state gates it.
    always_ff @(posedge clk) begin
        prev_valid <= cur_valid;
        prev_ready <= cur_ready;
        prev_data  <= cur_data;
    end

endmodule

// File: rtl/mon_rule_eval.sv
module mon_rule_eval
    import mon_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              hist_warm,
    input  logic              cur_valid,
    input  logic              cur_ready,
    input  logic [DATA_W-1:0] cur_data,
    input  logic              prev_valid,
    input  logic              prev_ready,
    input  logic [DATA_W-1:0] prev_data,
    output logic              hit_valid_drop,
    output logic              hit_ready_drop,
    output logic              hit_data_change
);

    logic prev_stalled;

    always_comb begin
        prev_stalled    = prev_valid && !prev_ready;
        hit_valid_drop  = hist_warm && prev_stalled && !cur_valid;
        hit_ready_drop  = hist_warm && prev_ready && !prev_valid && !cur_ready;
        hit_data_change = hist_warm && prev_stalled && (cur_data != prev_data);
    end

endmodule

// File: rtl/mon_stall_timer.sv
module mon_stall_timer
    import mon_pkg::*;
#(
    parameter int STALL_LIMIT = 1000,
    localparam int CNT_W = $clog2(STALL_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall,
    output logic [CNT_W-1:0] count,
    output logic             expire_hit
);

    localparam logic [CNT_W-1:0] LIM_C = CNT_W'(STALL_LIMIT);
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

    stall_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State and count register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= STL_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            STL_IDLE: begin
                if (stall) begin
                    state_d = (LIM_C == ONE_C) ? STL_EXPIRED : STL_STALLING;
                    cnt_d   = ONE_C;
                end else begin
                    cnt_d = '0;
                end
            end
            STL_STALLING: begin
                if (!stall) begin
                    state_d = STL_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q + ONE_C == LIM_C) begin
                    state_d = STL_EXPIRED;
                    cnt_d   = LIM_C;
                end else begin
                    cnt_d = cnt_q + ONE_C;
                end
            end
            STL_EXPIRED: begin
                if (!stall) begin
                    state_d = STL_IDLE;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = STL_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        count      = cnt_q;
        expire_hit = (state_q != STL_EXPIRED) && (state_d == STL_EXPIRED);
    end

endmodule

// File: rtl/mon_sticky_flags.sv
module mon_sticky_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_in,
    output logic [N-1:0] flags
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         flags[i] <= 1'b0;
            else if (set_in[i]) flags[i] <= 1'b1;
        end
    end

endmodule

// File: rtl/stream_proto_monitor.sv
module stream_proto_monitor
    import mon_pkg::*;
#(
    parameter int   DATA_W        = 32,
    parameter int   STALL_LIMIT   = 1000,
    parameter logic MASTER_IS_DUT = 1'b1,
    localparam int  CNT_W         = $clog2(STALL_LIMIT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mon_valid,
    input  logic              mon_ready,
    input  logic [DATA_W-1:0] mon_data,
    output logic              err_valid_drop,
    output logic              err_ready_drop,
    output logic              err_data_change,
    output logic              err_timeout,
    output logic              err_any,
    output logic              dut_err,
    output logic              env_err,
    output logic [CNT_W-1:0]  stall_count
);

    localparam flag_vec_t DUT_MASK = side_mask(MASTER_IS_DUT);

    logic              hist_warm;
    logic              prev_valid;
    logic              prev_ready;
    logic [DATA_W-1:0] prev_data;
    logic              hit_valid_drop;
    logic              hit_ready_drop;
    logic              hit_data_change;
    logic              hit_timeout;
    flag_vec_t         hit_vec;
    flag_vec_t         flag_vec;

    mon_history #(.DATA_W(DATA_W)) u_history (
        .clk        (clk),
        .rst_n      (rst_n),
        .cur_valid  (mon_valid),
        .cur_ready  (mon_ready),
        .cur_data   (mon_data),
        .hist_warm  (hist_warm),
        .prev_valid (prev_valid),
        .prev_ready (prev_ready),
        .prev_data  (prev_data)
    );

    mon_rule_eval #(.DATA_W(DATA_W)) u_rules (
        .hist_warm       (hist_warm),
        .cur_valid       (mon_valid),
        .cur_ready       (mon_ready),
        .cur_data        (mon_data),
        .prev_valid      (prev_valid),
        .prev_ready      (prev_ready),
        .prev_data       (prev_data),
        .hit_valid_drop  (hit_valid_drop),
        .hit_ready_drop  (hit_ready_drop),
        .hit_data_change (hit_data_change)
    );

    mon_stall_timer #(.STALL_LIMIT(STALL_LIMIT)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .stall      (mon_valid && !mon_ready),
        .count      (stall_count),
        .expire_hit (hit_timeout)
    );

    always_comb begin
        hit_vec                   = '0;
        hit_vec[FLAG_VALID_DROP]  = hit_valid_drop;
        hit_vec[FLAG_READY_DROP]  = hit_ready_drop;
        hit_vec[FLAG_DATA_CHANGE] = hit_data_change;
        hit_vec[FLAG_TIMEOUT]     = hit_timeout;
    end

    mon_sticky_flags #(.N(NUM_FLAGS)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_in (hit_vec),
        .flags  (flag_vec)
    );

    always_comb begin
        err_valid_drop  = flag_vec[FLAG_VALID_DROP];
        err_ready_drop  = flag_vec[FLAG_READY_DROP];
        err_data_change = flag_vec[FLAG_DATA_CHANGE];
        err_timeout     = flag_vec[FLAG_TIMEOUT];
        err_any         = |flag_vec;
        dut_err         = |(flag_vec & DUT_MASK);
        env_err         = |(flag_vec & ~DUT_MASK);
    end

endmodule

// File: rtl/mon_protocol_checker.sv
module mon_protocol_checker #(
    parameter int  DATA_W      = 32,
    parameter int  STALL_LIMIT = 1000,
    localparam int CNT_W       = $clog2(STALL_LIMIT + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mon_valid,
    input logic              mon_ready,
    input logic [DATA_W-1:0] mon_data,
    input logic              err_valid_drop,
    input logic              err_ready_drop,
    input logic              err_data_change,
    input logic              err_timeout,
    input logic              err_any,
    input logic              dut_err,
    input logic              env_err,
    input logic [CNT_W-1:0]  stall_count
);

    // Set once a clock edge has been sampled out of reset.
    logic ck_warm;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ck_warm <= 1'b0;
        else        ck_warm <= 1'b1;
    end

    a_r2_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_warm && $past(mon_valid) && !$past(mon_ready) && !mon_valid) |=> err_valid_drop);

    a_r3_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_warm && $past(mon_ready) && !$past(mon_valid) && !mon_ready) |=> err_ready_drop);

    a_r4_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_warm && $past(mon_valid) && !$past(mon_ready) && (mon_data != $past(mon_data)))
        |=> err_data_change);

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err_any) |-> err_any);

    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !(mon_valid && !mon_ready) |=> (stall_count == '0));

    a_r9_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(stall_count) <= STALL_LIMIT);

    a_r9_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(stall_count) == STALL_LIMIT) |-> err_timeout);

    a_r10_split: assert property (@(posedge clk) disable iff (!rst_n)
        err_any |-> (dut_err || env_err));

endmodule

bind stream_proto_monitor mon_protocol_checker #(
    .DATA_W      (DATA_W),
    .STALL_LIMIT (STALL_LIMIT)
) i_mon_protocol_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .mon_valid       (mon_valid),
    .mon_ready       (mon_ready),
    .mon_data        (mon_data),
    .err_valid_drop  (err_valid_drop),
    .err_ready_drop  (err_ready_drop),
    .err_data_change (err_data_change),
    .err_timeout     (err_timeout),
    .err_any         (err_any),
    .dut_err         (dut_err),
    .env_err         (env_err),
    .stall_count     (stall_count)
);

// File: tb/test_stream_proto_monitor.sv
`timescale 1ns/100ps
module test_stream_proto_monitor;

    localparam int DATA_W = 32;
    localparam int LIMIT  = 1000;
    localparam int CNT_W  = $clog2(LIMIT + 1);
    localparam int NV     = 28;

    // Row: {reset, valid, ready, data[7:0], expected flags {to,dc,rd,vd}, expected count[3:0]}
    localparam logic [18:0] VECS [NV] = '{
        {1'b1,1'b0,1'b0,8'h00,4'b0000,4'd0},
        {1'b0,1'b1,1'b0,8'h05,4'b0000,4'd1},
        {1'b0,1'b1,1'b1,8'h05,4'b0000,4'd0},
        {1'b0,1'b0,1'b1,8'h00,4'b0000,4'd0},
        {1'b0,1'b1,1'b1,8'h11,4'b0000,4'd0},
        {1'b0,1'b1,1'b1,8'h22,4'b0000,4'd0},
        {1'b0,1'b1,1'b0,8'h33,4'b0000,4'd1},
        {1'b0,1'b1,1'b0,8'h33,4'b0000,4'd2},
        {1'b0,1'b1,1'b1,8'h33,4'b0000,4'd0},
        {1'b0,1'b0,1'b0,8'h00,4'b0000,4'd0},
        {1'b0,1'b0,1'b1,8'h00,4'b0000,4'd0},
        {1'b0,1'b0,1'b0,8'h00,4'b0010,4'd0},
        {1'b0,1'b1,1'b0,8'h44,4'b0010,4'd1},
        {1'b1,1'b0,1'b0,8'h00,4'b0000,4'd0},
        {1'b0,1'b1,1'b0,8'h07,4'b0000,4'd1},
        {1'b0,1'b0,1'b0,8'h07,4'b0001,4'd0},
        {1'b1,1'b1,1'b0,8'h03,4'b0000,4'd0},
        {1'b0,1'b0,1'b0,8'h00,4'b0000,4'd0},
        {1'b0,1'b1,1'b0,8'h0A,4'b0000,4'd1},
        {1'b0,1'b1,1'b0,8'h0B,4'b0100,4'd2},
        {1'b0,1'b1,1'b1,8'h0B,4'b0100,4'd0},
        {1'b0,1'b0,1'b0,8'h0B,4'b0100,4'd0},
        {1'b1,1'b1,1'b0,8'h0C,4'b0000,4'd0},
        {1'b0,1'b1,1'b0,8'h0D,4'b0000,4'd1},
        {1'b0,1'b1,1'b0,8'h0D,4'b0000,4'd2},
        {1'b0,1'b0,1'b1,8'h0D,4'b0001,4'd0},
        {1'b0,1'b1,1'b0,8'h0E,4'b0011,4'd1},
        {1'b0,1'b1,1'b0,8'h0F,4'b0111,4'd2}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mon_valid = 1'b0;
    logic              mon_ready = 1'b0;
    logic [DATA_W-1:0] mon_data = '0;
    logic              e_vd, e_rd, e_dc, e_to, e_any, e_dut, e_env;
    logic [CNT_W-1:0]  e_cnt;
    logic              s_vd, s_rd, s_dc, s_to, s_any, s_dut, s_env;
    logic [CNT_W-1:0]  s_cnt;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    stream_proto_monitor #(.DATA_W(DATA_W), .STALL_LIMIT(LIMIT), .MASTER_IS_DUT(1'b1))
    i_stream_proto_monitor (
        .clk(clk), .rst_n(rst_n), .mon_valid(mon_valid), .mon_ready(mon_ready),
        .mon_data(mon_data), .err_valid_drop(e_vd), .err_ready_drop(e_rd),
        .err_data_change(e_dc), .err_timeout(e_to), .err_any(e_any),
        .dut_err(e_dut), .env_err(e_env), .stall_count(e_cnt)
    );

    stream_proto_monitor #(.DATA_W(DATA_W), .STALL_LIMIT(LIMIT), .MASTER_IS_DUT(1'b0))
    i_stream_proto_monitor_slv (
        .clk(clk), .rst_n(rst_n), .mon_valid(mon_valid), .mon_ready(mon_ready),
        .mon_data(mon_data), .err_valid_drop(s_vd), .err_ready_drop(s_rd),
        .err_data_change(s_dc), .err_timeout(s_to), .err_any(s_any),
        .dut_err(s_dut), .env_err(s_env), .stall_count(s_cnt)
    );

    // Compare both instances against expected flags {to,dc,rd,vd} and count.
    task automatic check_all(input string tag, input logic [3:0] ef, input int ec);
        logic [3:0] af;
        logic [3:0] asf;
        logic       edut, eenv;
        af   = {e_to, e_dc, e_rd, e_vd};
        asf  = {s_to, s_dc, s_rd, s_vd};
        edut = ef[0] | ef[2];
        eenv = ef[1] | ef[3];
        n_checks++;
        if (af !== ef || asf !== ef || int'(e_cnt) != ec || int'(s_cnt) != ec ||
            e_any !== (|ef) || e_dut !== edut || e_env !== eenv ||
            s_dut !== eenv || s_env !== edut) begin
            n_fails++;
            $display("FAIL %s: flags=%b/%b cnt=%0d any=%b dut=%b env=%b sdut=%b senv=%b expected flags=%b cnt=%0d dut=%b env=%b",
                     tag, af, asf, e_cnt, e_any, e_dut, e_env, s_dut, s_env, ef, ec, edut, eenv);
        end
    endtask

    task automatic step(input logic rst, input logic v, input logic r, input logic [7:0] d);
        @(negedge clk);
        rst_n     = ~rst;
        mon_valid = v;
        mon_ready = r;
        mon_data  = {{(DATA_W-8){1'b0}}, d};
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #1;
        // R1: outputs quiet while in reset
        check_all("R1 reset state", 4'b0000, 0);
        step(1'b1, 1'b1, 1'b0, 8'h00);
        check_all("R1 reset held", 4'b0000, 0);

        // Table: R2 R3 R4 R5 R6 R7 R8 R10
        for (int i = 0; i < NV; i++) begin
            step(VECS[i][18], VECS[i][17], VECS[i][16], VECS[i][15:8]);
            check_all($sformatf("R2/R3/R4/R5/R6/R7/R8/R10 vector %0d", i),
                      VECS[i][7:4], int'(VECS[i][3:0]));
        end

        // R9: timeout boundary and saturation
        step(1'b1, 1'b0, 1'b0, 8'h00);
        check_all("R1 reset before timeout run", 4'b0000, 0);
        for (int k = 0; k < LIMIT - 1; k++) step(1'b0, 1'b1, 1'b0, 8'h5A);
        check_all("R9 one below limit", 4'b0000, LIMIT - 1);
        step(1'b0, 1'b1, 1'b0, 8'h5A);
        check_all("R9 limit reached", 4'b1000, LIMIT);
        for (int k = 0; k < 5; k++) step(1'b0, 1'b1, 1'b0, 8'h5A);
        check_all("R9 saturated", 4'b1000, LIMIT);
        step(1'b0, 1'b1, 1'b1, 8'h5A);
        check_all("R7 R8 timeout sticky after stall ends", 4'b1000, 0);
        step(1'b1, 1'b0, 1'b0, 8'h00);
        check_all("R7 reset clears sticky", 4'b0000, 0);

        finish_run();
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

endmodule